// File: doc/BRIEF.md
# Phase-Offset Exclusive-OR PWM Generator

This block generates several pulse-width-modulated outputs. It does not compare a counter against a threshold. Instead, one free-running master square wave is shared by all channels. Each channel runs a slave square wave at the same frequency, and the channel output is the exclusive-OR of the two waves. The width of each pulse equals the phase lead of the slave wave over the master wave. Both waves come from 32-bit phase accumulators that add the same step on every clock. The square wave is the top bit of the accumulator, and the step is 2^31 shifted right by the resolution parameter `RES_BITS`. The square wave therefore has a period of 2^(RES_BITS+1) clocks, and the PWM output repeats every 2^RES_BITS clocks.

A duty change takes effect without waiting for a master edge. When a channel's write strobe is high, the channel adds (new − old) · 2^(31−RES_BITS) to its slave accumulator and keeps the new value, both on that same clock edge. The phase offset therefore always equals the stored duty value. A duty value of zero gives a constant-low output. The largest value, 2^RES_BITS − 1, leaves one low clock in every period. A per-channel force input drives the output fully high for a true 100%.

Top module: `xpwm_top`

## Requirements
- R1: `master_o` is low after reset. With n rising clock edges since reset was released, `master_o` equals bit `RES_BITS` of n. It is a square wave with a period of 2^(RES_BITS+1) clocks.
- R2: When channel c is not forced and d is its stored duty value, `pwm_o[c]` equals bit `RES_BITS` of n XOR bit `RES_BITS` of (n + d). Over any aligned window of 2^RES_BITS clocks it is high for exactly d clocks.
- R3: Channel c takes its duty value from bits [c*VAL_W +: VAL_W] of `duty_i`. Only the low `RES_BITS` bits of that field are used, and the higher bits have no effect.
- R4: A write strobe may be given on any cycle. The new duty value applies from the same rising edge that samples the strobe, and the output after that edge already follows R2 with the new value.
- R5: A synchronous reset clears every accumulator and every stored duty value. After it, `master_o` is low and every unforced `pwm_o` bit is low.
- R6: While `full_i[c]` is high, `pwm_o[c]` is high. Forcing does not disturb the channel's phase, so on release the output again follows R2 with the stored value.
- R7: A stored duty of zero keeps the output constantly low. The maximum value 2^RES_BITS − 1 gives exactly one low clock per period.
- R8: Channels are independent. A write to one channel leaves the output pattern of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | NUM_CH*VAL_W | Packed per-channel duty values |
| wr_i | input | NUM_CH | Per-channel duty write strobes |
| full_i | input | NUM_CH | Per-channel force-to-100% requests |
| pwm_o | output | NUM_CH | PWM outputs |
| master_o | output | 1 | Shared master square wave |

## Verification
The bench builds the block with `RES_BITS = 3`, `VAL_W = 8` and two channels. This gives a PWM period of only eight clocks, so every duty value from 0 to 7 can be swept on both channels and each output compared with the arithmetic model on every cycle. The 8-bit duty field leaves high bits above the 3-bit resolution, which lets the bench show that they are masked off. With two channels, a write to one channel can be checked against the unchanged pattern of the other. Writes land at many different points in the master phase, and a reset in the middle of the run is also covered.

// File: rtl/xpwm_pkg.sv
package xpwm_pkg;
    localparam int ACC_W = 32;
    typedef logic [ACC_W-1:0] acc_t;

    function automatic acc_t phase_step(input int res_bits);
        return acc_t'(32'h8000_0000) >> res_bits;
    endfunction
endpackage

// File: rtl/xpwm_master.sv
module xpwm_master
    import xpwm_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic clk,
    input  logic rst,
    output logic wave_o
);
    localparam acc_t STEP = phase_step(RES_BITS);

    typedef struct packed {
        acc_t acc;
    } mst_state_t;

    mst_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) st_d.acc = '0;
        else     st_d.acc = st_q.acc + STEP;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign wave_o = st_q.acc[ACC_W-1];
endmodule

// File: rtl/xpwm_channel.sv
module xpwm_channel
    import xpwm_pkg::*;
#(
    parameter int RES_BITS = 12,
    parameter int VAL_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [VAL_W-1:0] duty_i,
    input  logic             full_i,
    input  logic             master_i,
    output logic             pwm_o
);
    localparam acc_t STEP  = phase_step(RES_BITS);
    localparam int   SHIFT = 31 - RES_BITS;

    typedef struct packed {
        acc_t                acc;
        logic [RES_BITS-1:0] prev;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic [RES_BITS-1:0] val;
    acc_t delta;

    // Only the low RES_BITS bits carry duty; the rest are dropped.
    assign val = duty_i[RES_BITS-1:0];

    generate
        if (VAL_W > RES_BITS) begin : g_hi
            logic unused_hi_bits;
            assign unused_hi_bits = ^duty_i[VAL_W-1:RES_BITS];
        end
    endgenerate

    // Difference taken in full accumulator width so a negative step wraps correctly.
    assign delta = (acc_t'(val) - acc_t'(st_q.prev)) << SHIFT;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.acc  = '0;
            st_d.prev = '0;
        end else if (wr_i) begin
            st_d.acc  = st_q.acc + STEP + delta;
            st_d.prev = val;
        end else begin
            st_d.acc  = st_q.acc + STEP;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign pwm_o = full_i | (master_i ^ st_q.acc[ACC_W-1]);
endmodule

// File: rtl/xpwm_top.sv
module xpwm_top #(
    parameter int NUM_CH   = 4,
    parameter int RES_BITS = 12,
    parameter int VAL_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CH*VAL_W-1:0] duty_i,
    input  logic [NUM_CH-1:0]       wr_i,
    input  logic [NUM_CH-1:0]       full_i,
    output logic [NUM_CH-1:0]       pwm_o,
    output logic                    master_o
);
    logic master_w;

    xpwm_master #(.RES_BITS(RES_BITS)) u_master (
        .clk    (clk),
        .rst    (rst),
        .wave_o (master_w)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            xpwm_channel #(.RES_BITS(RES_BITS), .VAL_W(VAL_W)) u_ch (
                .clk      (clk),
                .rst      (rst),
                .wr_i     (wr_i[c]),
                .duty_i   (duty_i[c*VAL_W +: VAL_W]),
                .full_i   (full_i[c]),
                .master_i (master_w),
                .pwm_o    (pwm_o[c])
            );
        end
    endgenerate

    assign master_o = master_w;
endmodule

// File: rtl/xpwm_checker.sv
module xpwm_checker #(
    parameter int NUM_CH   = 4,
    parameter int RES_BITS = 12,
    parameter int VAL_W    = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NUM_CH*VAL_W-1:0] duty_i,
    input logic [NUM_CH-1:0]       wr_i,
    input logic [NUM_CH-1:0]       full_i,
    input logic [NUM_CH-1:0]       pwm_o,
    input logic                    master_o
);
    logic [31:0] edges_q;

    always_ff @(posedge clk) begin
        if (rst) edges_q <= '0;
        else     edges_q <= edges_q + 32'd1;
    end

    // R1: master level follows the edge count since reset
    a_r1_master_phase: assert property (@(posedge clk) disable iff (rst)
        master_o == edges_q[RES_BITS]);

    // R5: outputs low right after reset
    a_r5_reset_low: assert property (@(posedge clk)
        rst |=> (!master_o && ((pwm_o & ~full_i) == '0)));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            logic [RES_BITS-1:0] seen_q;

            always_ff @(posedge clk) begin
                if (rst)        seen_q <= '0;
                else if (wr_i[c]) seen_q <= duty_i[c*VAL_W +: RES_BITS];
            end

            // R6: forced channel is high
            a_r6_force_high: assert property (@(posedge clk) disable iff (rst)
                full_i[c] |-> pwm_o[c]);

            // R7: zero duty holds the output low
            a_r7_zero_low: assert property (@(posedge clk) disable iff (rst)
                (seen_q == '0 && !full_i[c]) |-> !pwm_o[c]);
        end
    endgenerate
endmodule

bind xpwm_top xpwm_checker #(
    .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .VAL_W(VAL_W)
) u_xpwm_checker (
    .clk(clk), .rst(rst), .duty_i(duty_i), .wr_i(wr_i),
    .full_i(full_i), .pwm_o(pwm_o), .master_o(master_o)
);

// File: tb/tb_xpwm_top.sv
module tb_xpwm_top;
    localparam int NCH = 2;
    localparam int RB  = 3;
    localparam int VW  = 8;
    localparam int PER = 1 << RB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH*VW-1:0] duty = '0;
    logic [NCH-1:0] wr = '0;
    logic [NCH-1:0] full = '0;
    logic [NCH-1:0] pwm;
    logic mst;

    int n_m;
    int d_m [NCH];
    int hi  [NCH];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    xpwm_top #(.NUM_CH(NCH), .RES_BITS(RB), .VAL_W(VW)) dut (
        .clk(clk), .rst(rst), .duty_i(duty), .wr_i(wr),
        .full_i(full), .pwm_o(pwm), .master_o(mst)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pwm(input int c);
        if (full[c]) return 1;
        return ((n_m >> RB) & 1) ^ (((n_m + d_m[c]) >> RB) & 1);
    endfunction

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            n_m = 0;
            for (int c = 0; c < NCH; c++) d_m[c] = 0;
        end else begin
            n_m++;
            for (int c = 0; c < NCH; c++)
                if (wr[c]) d_m[c] = int'(duty[c*VW +: VW]) & (PER - 1);
        end
        #5;
    endtask

    task automatic run(input int k, input string tag);
        for (int c = 0; c < NCH; c++) hi[c] = 0;
        for (int i = 0; i < k; i++) begin
            tick();
            chk("R1 master wave", int'(mst), (n_m >> RB) & 1);
            for (int c = 0; c < NCH; c++) begin
                chk(tag, int'(pwm[c]), exp_pwm(c));
                if (i >= k - PER) hi[c] += int'(pwm[c]);
            end
        end
    endtask

    initial begin
        repeat (3) tick();
        chk("R5 reset master", int'(mst), 0);
        chk("R5 reset pwm", int'(pwm), 0);
        rst = 1'b0;
        run(20, "R2 idle pattern");
        chk("R7 zero duty ch0", hi[0], 0);
        chk("R7 zero duty ch1", hi[1], 0);

        for (int v = 0; v < PER; v++) begin
            duty[0 +: VW]  = VW'(v);
            duty[VW +: VW] = VW'(PER - 1 - v);
            wr = '1;
            run(1, "R4 write same edge");
            wr = '0;
            run(2 * PER + v, "R2 sweep pattern");
            chk("R2 high count ch0", hi[0], v);
            chk("R2 high count ch1", hi[1], PER - 1 - v);
            if (v == PER - 1) chk("R7 max leaves one low", PER - hi[0], 1);
        end

        duty[0 +: VW] = VW'(2);
        wr[0] = 1'b1;
        run(1, "R8 single write");
        wr[0] = 1'b0;
        run(2 * PER, "R8 other channel steady");
        chk("R8 ch1 unchanged", hi[1], 0);
        chk("R8 ch0 new duty", hi[0], 2);

        duty[VW +: VW] = 8'hAD;
        wr[1] = 1'b1;
        run(1, "R3 masked write");
        wr[1] = 1'b0;
        run(2 * PER, "R3 masked pattern");
        chk("R3 high bits ignored", hi[1], 5);

        full[1] = 1'b1;
        run(12, "R6 forced");
        chk("R6 forced full", hi[1], PER);
        full[1] = 1'b0;
        run(2 * PER, "R6 release");
        chk("R6 phase kept", hi[1], 5);

        rst = 1'b1;
        tick();
        chk("R5 mid reset master", int'(mst), 0);
        chk("R5 mid reset pwm", int'(pwm), 0);
        rst = 1'b0;
        run(2 * PER, "R5 after reset");
        chk("R5 duty cleared ch0", hi[0], 0);
        chk("R5 duty cleared ch1", hi[1], 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule